// File: doc/BRIEF.md
# Transmit Sample FIFO with Burst Request and Underrun Substitution

This block is the per-channel sample queue in front of a digital audio frame builder. An upstream unpacker pushes samples through a write port. The frame builder pulls one sample at a time through a request port. One cycle after each request, the block presents either the oldest stored sample or a substitute zero sample, together with the validity bit that goes into the frame.

The block requests DMA bursts by raising a burst-ready flag. The flag is high while the free space in the queue can take a whole burst of a programmed length. Two sticky flags record errors: an underrun, where a request arrives while the queue is empty, and an overrun, where a write arrives while the queue is full. A transmit enable gates every pull. While the enable is low, requests do nothing.

Top module: `tx_sample_fifo`

## Requirements
- R1: Samples leave in the order they were accepted. `level_o` gives the number of stored entries. `empty_o` is high exactly when the level is 0, and `full_o` is high exactly when the level is DEPTH.
- R2: `burst_rdy_o` is high while DEPTH minus the level is at least the effective burst length. The effective burst length is `burst_len_i`, except that a value of 0 counts as 1.
- R3: When `burst_len_i` is larger than DEPTH, `burst_rdy_o` stays low at every level.
- R4: A request with `tx_en_i` high and the queue not empty pops the head entry. In the next cycle `smp_valid_o` is 1, `smp_data_o` is that entry, `smp_vbit_o` equals `ch_vbit_i` as sampled with the request, and `smp_fill_o` is 0.
- R5: A request with `tx_en_i` high and the queue empty is an underrun. In the next cycle `smp_valid_o` is 1, `smp_data_o` is all zeros and `smp_fill_o` is 1, and `underrun_o` is set. With `fill_ok_i` low, `smp_vbit_o` is 1, which marks the frame invalid.
- R6: On an underrun with `fill_ok_i` high, `smp_vbit_o` is 0, which marks the substitute frame valid.
- R7: While `tx_en_i` is low, a request has no effect. `smp_valid_o` is 0 in the next cycle, no entry is popped, and `underrun_o` is not set.
- R8: A write while `full_o` is high is discarded and sets `overrun_o`. A write while `full_o` is low is stored, even if a pop happens in the same cycle.
- R9: `underrun_o` and `overrun_o` stay set until their clear input is pulsed. If a new error event arrives in the same cycle as the clear, the flag stays set.
- R10: After reset the level is 0, `empty_o` is 1, `full_o`, `smp_valid_o`, `underrun_o` and `overrun_o` are 0, and `burst_rdy_o` follows R2 for an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; gates all pulls |
| burst_len_i | input | BURST_W | Burst length in entries (0 is treated as 1) |
| ch_vbit_i | input | 1 | Validity bit for frames built from stored samples |
| fill_ok_i | input | 1 | 1: substitute frames are marked valid; 0: marked invalid |
| clr_underrun_i | input | 1 | Clears the sticky underrun flag |
| clr_overrun_i | input | 1 | Clears the sticky overrun flag |
| wr_en_i | input | 1 | Write strobe from the unpacker |
| wr_data_i | input | DATA_W | Sample to write |
| req_i | input | 1 | Sample request from the frame builder |
| smp_valid_o | output | 1 | Sample output valid, one cycle after an enabled request |
| smp_data_o | output | DATA_W | Sample or substitute zero |
| smp_vbit_o | output | 1 | Validity bit for the frame (1 = invalid) |
| smp_fill_o | output | 1 | 1 when the sample is a substitute |
| level_o | output | CNT_W | Number of stored entries |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| burst_rdy_o | output | 1 | Free space holds a whole burst |
| underrun_o | output | 1 | Sticky underrun flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with DEPTH 8, DATA_W 24 and BURST_W 5. With these values the queue fills and overflows within a dozen writes. A 5-bit burst length also reaches values from 9 to 31, so the case of a burst longer than the queue (R3) can be driven directly, next to the zero value and the boundary where free space equals the burst length.

// File: rtl/tx_sfifo_pkg.sv
package tx_sfifo_pkg;
  // side information travelling with each output sample
  typedef struct packed {
    logic vbit;
    logic fill;
  } smp_meta_t;
endpackage

// File: rtl/tx_sfifo_mem.sv
module tx_sfifo_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 24,
  parameter int PTR_W  = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (we_i && wr_ptr_i == PTR_W'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/tx_sfifo_ctrl.sv
module tx_sfifo_ctrl #(
  parameter int DEPTH   = 8,
  parameter int BURST_W = 5,
  parameter int PTR_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               pop_i,
  input  logic               clr_overrun_i,
  input  logic [BURST_W-1:0] burst_len_i,
  output logic               wr_ok_o,
  output logic [PTR_W-1:0]   wr_ptr_o,
  output logic [PTR_W-1:0]   rd_ptr_o,
  output logic [CNT_W-1:0]   level_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               burst_rdy_o,
  output logic               overrun_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  int unsigned      eff_len, free_cnt;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok_o = wr_en_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)   rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok_o, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      // a new event wins over a clear in the same cycle
      if (wr_en_i && full_o) ovr_q <= 1'b1;
      else if (clr_overrun_i) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    eff_len     = (burst_len_i == '0) ? 32'd1 : 32'(burst_len_i);
    free_cnt    = 32'(DEPTH) - 32'(cnt_q);
    burst_rdy_o = (eff_len <= 32'(DEPTH)) && (free_cnt >= eff_len);
  end

  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign level_o   = cnt_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/tx_sfifo_out.sv
module tx_sfifo_out
  import tx_sfifo_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              req_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              ch_vbit_i,
  input  logic              fill_ok_i,
  input  logic              clr_underrun_i,
  output logic              pop_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_vbit_o,
  output logic              smp_fill_o,
  output logic              underrun_o
);
  logic              take, starve;
  logic              vld_q, und_q;
  logic [DATA_W-1:0] data_q;
  smp_meta_t         meta_q;

  assign take   = tx_en_i && req_i;
  assign pop_o  = take && !empty_i;
  assign starve = take && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      meta_q <= '0;
      und_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (pop_o) begin
        data_q <= head_i;
        meta_q <= '{vbit: ch_vbit_i, fill: 1'b0};
      end else if (starve) begin
        data_q <= '0;
        meta_q <= '{vbit: !fill_ok_i, fill: 1'b1};
      end
      if (starve) und_q <= 1'b1;
      else if (clr_underrun_i) und_q <= 1'b0;
    end
  end

  assign smp_valid_o = vld_q;
  assign smp_data_o  = data_q;
  assign smp_vbit_o  = meta_q.vbit;
  assign smp_fill_o  = meta_q.fill;
  assign underrun_o  = und_q;
endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 24,
  parameter int BURST_W = 5,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic [BURST_W-1:0] burst_len_i,
  input  logic               ch_vbit_i,
  input  logic               fill_ok_i,
  input  logic               clr_underrun_i,
  input  logic               clr_overrun_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               req_i,
  output logic               smp_valid_o,
  output logic [DATA_W-1:0]  smp_data_o,
  output logic               smp_vbit_o,
  output logic               smp_fill_o,
  output logic [CNT_W-1:0]   level_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               burst_rdy_o,
  output logic               underrun_o,
  output logic               overrun_o
);
  logic              wr_ok, pop;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] head;

  tx_sfifo_ctrl #(
    .DEPTH(DEPTH), .BURST_W(BURST_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .pop_i         (pop),
    .clr_overrun_i (clr_overrun_i),
    .burst_len_i   (burst_len_i),
    .wr_ok_o       (wr_ok),
    .wr_ptr_o      (wr_ptr),
    .rd_ptr_o      (rd_ptr),
    .level_o       (level_o),
    .empty_o       (empty_o),
    .full_o        (full_o),
    .burst_rdy_o   (burst_rdy_o),
    .overrun_o     (overrun_o)
  );

  tx_sfifo_mem #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_mem (
    .clk_i     (clk_i),
    .we_i      (wr_ok),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (head)
  );

  tx_sfifo_out #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_en_i        (tx_en_i),
    .req_i          (req_i),
    .empty_i        (empty_o),
    .head_i         (head),
    .ch_vbit_i      (ch_vbit_i),
    .fill_ok_i      (fill_ok_i),
    .clr_underrun_i (clr_underrun_i),
    .pop_o          (pop),
    .smp_valid_o    (smp_valid_o),
    .smp_data_o     (smp_data_o),
    .smp_vbit_o     (smp_vbit_o),
    .smp_fill_o     (smp_fill_o),
    .underrun_o     (underrun_o)
  );
endmodule

// File: rtl/tx_sfifo_chk.sv
module tx_sfifo_chk #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 24,
  parameter int BURST_W = 5,
  parameter int CNT_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_en_i,
  input logic [BURST_W-1:0] burst_len_i,
  input logic               ch_vbit_i,
  input logic               fill_ok_i,
  input logic               clr_underrun_i,
  input logic               clr_overrun_i,
  input logic               wr_en_i,
  input logic               req_i,
  input logic               smp_valid_o,
  input logic [DATA_W-1:0]  smp_data_o,
  input logic               smp_vbit_o,
  input logic               smp_fill_o,
  input logic [CNT_W-1:0]   level_o,
  input logic               empty_o,
  input logic               full_o,
  input logic               burst_rdy_o,
  input logic               underrun_o,
  input logic               overrun_o
);
  int unsigned eff_len;
  assign eff_len = (burst_len_i == '0) ? 32'd1 : 32'(burst_len_i);

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_o) <= 32'(DEPTH) && !(empty_o && full_o));

  assert_burst_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_rdy_o |-> (32'(DEPTH) - 32'(level_o)) >= eff_len);

  assert_burst_oversize_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(burst_len_i) > 32'(DEPTH)) |-> !burst_rdy_o);

  assert_real_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && req_i && !empty_o) |=>
      (smp_valid_o && !smp_fill_o && smp_vbit_o == $past(ch_vbit_i)));

  assert_fill_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && req_i && empty_o) |=>
      (smp_valid_o && smp_fill_o && smp_data_o == '0 && underrun_o));

  assert_fill_vbit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && req_i && empty_o) |=> (smp_vbit_o == !$past(fill_ok_i)));

  assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !wr_en_i) |=> (!smp_valid_o && $stable(level_o)));

  assert_overrun_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> overrun_o);

  assert_overrun_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_overrun_i) |=> overrun_o);

  assert_underrun_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !clr_underrun_i) |=> underrun_o);
endmodule

bind tx_sample_fifo tx_sfifo_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .BURST_W(BURST_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_en_i        (tx_en_i),
  .burst_len_i    (burst_len_i),
  .ch_vbit_i      (ch_vbit_i),
  .fill_ok_i      (fill_ok_i),
  .clr_underrun_i (clr_underrun_i),
  .clr_overrun_i  (clr_overrun_i),
  .wr_en_i        (wr_en_i),
  .req_i          (req_i),
  .smp_valid_o    (smp_valid_o),
  .smp_data_o     (smp_data_o),
  .smp_vbit_o     (smp_vbit_o),
  .smp_fill_o     (smp_fill_o),
  .level_o        (level_o),
  .empty_o        (empty_o),
  .full_o         (full_o),
  .burst_rdy_o    (burst_rdy_o),
  .underrun_o     (underrun_o),
  .overrun_o      (overrun_o)
);

// File: tb/tx_sample_fifo_tb.sv
`timescale 1ns/1ps
module tx_sample_fifo_tb;
  localparam int DEPTH = 8, DATA_W = 24, BURST_W = 5;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, ch_vbit = 0, fill_ok = 0, clr_u = 0, clr_o = 0, wr_en = 0, req = 0;
  logic [BURST_W-1:0] blen = 1;
  logic [DATA_W-1:0]  wdata = '0;
  logic smp_valid, smp_vbit, smp_fill, empty, full, brdy, und, ovr;
  logic [DATA_W-1:0] smp_data;
  logic [CNT_W-1:0]  level;

  always #4 clk = ~clk;

  tx_sample_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BURST_W(BURST_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .burst_len_i(blen),
    .ch_vbit_i(ch_vbit), .fill_ok_i(fill_ok), .clr_underrun_i(clr_u),
    .clr_overrun_i(clr_o), .wr_en_i(wr_en), .wr_data_i(wdata), .req_i(req),
    .smp_valid_o(smp_valid), .smp_data_o(smp_data), .smp_vbit_o(smp_vbit),
    .smp_fill_o(smp_fill), .level_o(level), .empty_o(empty), .full_o(full),
    .burst_rdy_o(brdy), .underrun_o(und), .overrun_o(ovr));

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  // reference model state
  logic [DATA_W-1:0] q[$];
  logic m_valid = 0, m_vbit = 0, m_fill = 0, m_und = 0, m_ovr = 0;
  logic [DATA_W-1:0] m_data = '0;
  string v_tag = "R4", u_tag = "R5", o_tag = "R8";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int unsigned eff;
    eff = (blen == 0) ? 1 : blen;
    chk("R1", "level", 32'(level), q.size());
    chk("R1", "empty", 32'(empty), 32'(q.size() == 0));
    chk("R1", "full", 32'(full), 32'(q.size() == DEPTH));
    chk((blen > DEPTH) ? "R3" : "R2", "burst_rdy", 32'(brdy),
        32'(eff <= DEPTH && (DEPTH - q.size()) >= eff));
    chk(tx_en || m_valid ? "R4" : "R7", "smp_valid", 32'(smp_valid), 32'(m_valid));
    if (m_valid) begin
      chk(v_tag, "smp_data", 32'(smp_data), 32'(m_data));
      chk(v_tag, "smp_vbit", 32'(smp_vbit), 32'(m_vbit));
      chk(v_tag, "smp_fill", 32'(smp_fill), 32'(m_fill));
    end
    chk(u_tag, "underrun", 32'(und), 32'(m_und));
    chk(o_tag, "overrun", 32'(ovr), 32'(m_ovr));
  endtask

  // one clock: model follows the inputs seen at the edge, compare at negedge
  task automatic step();
    bit take, was_full;
    @(posedge clk);
    take = tx_en && req;
    was_full = (q.size() == DEPTH);
    m_valid = take;
    u_tag = clr_u ? "R9" : "R5";
    o_tag = clr_o ? "R9" : "R8";
    if (take && q.size() > 0) begin
      m_data = q.pop_front(); m_vbit = ch_vbit; m_fill = 0; v_tag = "R4";
    end else if (take) begin
      m_data = '0; m_vbit = !fill_ok; m_fill = 1; m_und = 1;
      v_tag = fill_ok ? "R6" : "R5";
    end else if (clr_u) m_und = 0;
    if (take && q.size() == 0) ; else if (clr_u) m_und = 0;
    if (wr_en && !was_full) q.push_back(wdata);
    else if (wr_en) m_ovr = 1;
    else if (clr_o) m_ovr = 0;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_en = 0; req = 0; clr_u = 0; clr_o = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!done && cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset level", 32'(level), 0);
    chk("R10", "reset empty", 32'(empty), 1);
    chk("R10", "reset flags", {28'd0, full, smp_valid, und, ovr}, 0);
    chk("R10", "reset burst_rdy", 32'(brdy), 1);

    // fill beyond capacity, sweeping burst length (R1 R2 R8)
    tx_en = 1;
    for (int i = 0; i < 10; i++) begin
      wr_en = 1; wdata = 24'h100 + 24'(i * 7); blen = BURST_W'(i % 9);
      step();
    end
    idle();
    blen = 0; step();
    blen = 12; step();   // R3 oversized
    blen = 31; step();
    blen = 8; step();
    // clear overrun together with a new overflow write: set wins (R9)
    wr_en = 1; wdata = 24'hBAD; clr_o = 1; step();
    idle(); clr_o = 1; step();
    idle(); step();

    // drain with alternating channel validity (R4)
    for (int i = 0; i < DEPTH; i++) begin
      req = 1; ch_vbit = i[0]; blen = BURST_W'(i + 1);
      step();
    end
    // underrun, substitute marked invalid then valid (R5 R6)
    req = 1; fill_ok = 0; step();
    req = 1; fill_ok = 1; step();
    idle(); step();
    // gated requests with data present (R7)
    wr_en = 1; wdata = 24'hABCDEF; step();
    wr_en = 1; wdata = 24'h123456; step();
    idle(); tx_en = 0;
    for (int i = 0; i < 4; i++) begin req = 1; step(); end
    // clear underrun with a new underrun in same cycle (R9)
    tx_en = 1; req = 1; ch_vbit = 1; step();
    req = 1; step();
    req = 1; clr_u = 1; fill_ok = 0; step();
    idle(); clr_u = 1; step();
    idle(); step();
    // write and read together, including on an empty queue
    for (int i = 0; i < 12; i++) begin
      wr_en = (i % 3) != 2; wdata = 24'h5000 + 24'(i);
      req = (i % 2) == 0; ch_vbit = i[1]; blen = BURST_W'(i);
      step();
    end
    idle();
    for (int i = 0; i < 6; i++) begin req = 1; step(); end
    idle(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule